// File: doc/BRIEF.md
# Bank-Aware Round-Robin Read Arbiter

This block merges DRAM read requests from four ports into one access stream and orders them so that two accesses close together in time do not hit the same bank. Each port writes bank-tagged addresses into a small request FIFO of its own. The FIFO raises a full flag back to its port, and no request is ever lost.

Each cycle the arbiter scans the FIFO heads in round-robin order. It skips any head whose bank appears in a short history of recent issue slots. The chosen request goes out over a valid/ready handshake toward the memory controller. A slot in which nothing can issue puts an empty entry into the history, so blocked banks become free again over time.

A port that has been passed over too often becomes urgent. It then takes precedence over other ports as soon as its bank leaves the history.

Top module: `bank_rr_arbiter`

## Requirements
- R1: After reset, `outValid` is low, no `inFull` bit is set and the bank history is empty.
- R2: Requests from a port leave in the order they were pushed, with bank and address unchanged. A push taken while the FIFO is not full is never lost.
- R3: `inFull[p]` is high exactly when port p's FIFO holds FIFO_DEPTH entries. A push while full is ignored.
- R4: Among candidate ports, the grant goes to the first one found by scanning upward from the round-robin pointer, wrapping from the last port to port 0. When a request is accepted, the pointer moves to one past the granted port. It does not move at any other time.
- R5: A port's head request is eligible only if its bank differs from the banks of the last HIST_LEN history entries. The bank field is `$clog2(NUM_BANKS)` bits wide: 3 bits for 8 banks.
- R6: With no eligible head, `outValid` is low. Each such idle cycle shifts an empty entry into the history, which ages it.
- R7: While `outValid` is high and `outReady` is low, `outPort`, `outBank` and `outAddr` hold their values until acceptance. The history and the pointer are unchanged during the stall.
- R8: Each port counts accepted grants made while its FIFO was non-empty and it was not the granted port. The count saturates at STARVE_LIMIT and is cleared when the port is granted. Eligible ports at the limit are urgent. If any port is urgent, the round-robin scan considers only the urgent ports.
- R9: A request is accepted on a cycle with `outValid` and `outReady` both high. That cycle pops the granted port's FIFO and shifts the granted bank into the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inPush | input | NUM_PORTS | Per-port push strobe |
| inBank | input | NUM_PORTS*BANK_W | Per-port bank of the pushed request; port p uses bits [p*BANK_W +: BANK_W] |
| inAddr | input | NUM_PORTS*ADDR_W | Per-port address of the pushed request; port p uses bits [p*ADDR_W +: ADDR_W] |
| inFull | output | NUM_PORTS | Per-port FIFO full |
| outValid | output | 1 | An access is offered |
| outReady | input | 1 | Downstream accepts the offered access |
| outPort | output | PORT_W | Port of the offered access |
| outBank | output | BANK_W | Bank of the offered access |
| outAddr | output | ADDR_W | Address of the offered access |

## Verification
The hardest case to reach is a starving port that becomes eligible at the same moment as a port that is earlier in round-robin order but not urgent. Only then does the urgency rule change the result.

The stimulus sets this up with exact timing after a fresh reset. Port 0's request waits behind a bank in the history while three other ports are served. The competing port's request arrives on the very edge at which port 0's bank ages out, so that port's pass-over count is still zero.

Idle-slot aging and stalls are forced with directed patterns. A long random phase then runs all of these rules together against a transaction model.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;
  localparam int unsigned PORT_IDX_MAX = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic                    take;  // grant accepted this cycle
    logic                    idle;  // nothing offered: age history
    logic [PORT_IDX_MAX-1:0] port;  // granted port
  } arb_strobe_t;
endpackage

// File: rtl/rrarb_datapath.sv
module rrarb_datapath import rrarb_pkg::*; #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int HIST_LEN   = 3,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_PORTS-1:0]               inPush,
  input  logic [NUM_PORTS*BANK_W-1:0]        inBank,
  input  logic [NUM_PORTS*ADDR_W-1:0]        inAddr,
  output logic [NUM_PORTS-1:0]               inFull,
  input  arb_strobe_t                        strobe,
  output logic [NUM_PORTS-1:0]               headValid,
  output logic [NUM_PORTS-1:0][BANK_W-1:0]   headBank,
  output logic [NUM_BANKS-1:0]               bankBusy,
  output logic [BANK_W-1:0]                  outBank,
  output logic [ADDR_W-1:0]                  outAddr
);
  localparam int PTR_W   = $clog2(FIFO_DEPTH);
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int ENTRY_W = BANK_W + ADDR_W;

  logic [NUM_PORTS-1:0][ADDR_W-1:0] headAddr;
  logic [PORT_W-1:0] selPort;
  assign selPort = strobe.port[PORT_W-1:0];

  // per-port request FIFOs
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fifo
    logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0]   rdPtr, wrPtr;
    logic [CNT_W-1:0]   count;
    logic               doPush, doPop;

    assign inFull[p]    = (count == CNT_W'(FIFO_DEPTH));
    assign headValid[p] = (count != '0);
    assign doPush       = inPush[p] && !inFull[p];
    assign doPop        = strobe.take && (selPort == PORT_W'(p));
    assign {headBank[p], headAddr[p]} = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= {inBank[p*BANK_W +: BANK_W], inAddr[p*ADDR_W +: ADDR_W]};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (doPush) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (doPop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      end
    end
  end

  assign outBank = headBank[selPort];
  assign outAddr = headAddr[selPort];

  // recent-issue history: shifts on an accepted grant or an idle slot
  logic [BANK_W-1:0]   histBank [HIST_LEN];
  logic [HIST_LEN-1:0] histVld;
  logic                histShift;
  assign histShift = strobe.take || strobe.idle;

  always_ff @(posedge clk) begin
    if (rst) histVld <= '0;
    else if (histShift) histVld <= {histVld[HIST_LEN-2:0], strobe.take};
  end

  always_ff @(posedge clk) begin
    if (histShift) begin
      histBank[0] <= outBank;
      for (int i = 1; i < HIST_LEN; i++) histBank[i] <= histBank[i-1];
    end
  end

  always_comb begin
    bankBusy = '0;
    for (int i = 0; i < HIST_LEN; i++)
      if (histVld[i]) bankBusy[histBank[i]] = 1'b1;
  end
endmodule

// File: rtl/rrarb_control.sv
module rrarb_control import rrarb_pkg::*; #(
  parameter int NUM_PORTS    = 4,
  parameter int NUM_BANKS    = 8,
  parameter int STARVE_LIMIT = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0]             headValid,
  input  logic [NUM_PORTS-1:0][BANK_W-1:0] headBank,
  input  logic [NUM_BANKS-1:0]             bankBusy,
  input  logic                             outReady,
  output logic                             outValid,
  output logic [PORT_W-1:0]                outPort,
  output arb_strobe_t                      strobe
);
  localparam int SCNT_W = $clog2(STARVE_LIMIT + 1);

  logic [PORT_W-1:0]    rrPtr, lockPort, pickPort, grantPort;
  logic                 lockVld, take;
  logic [NUM_PORTS-1:0] eligible, urgent;
  logic [SCNT_W-1:0]    starveCnt [NUM_PORTS];

  function automatic logic [PORT_W-1:0] rrPick(input logic [NUM_PORTS-1:0] req,
                                               input logic [PORT_W-1:0] start);
    logic found;
    int   idx;
    rrPick = start;
    found  = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      idx = (int'(start) + k) % NUM_PORTS;
      if (!found && req[idx]) begin
        rrPick = PORT_W'(idx);
        found  = 1'b1;
      end
    end
  endfunction

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      eligible[p] = headValid[p] && !bankBusy[headBank[p]];
      urgent[p]   = eligible[p] && (starveCnt[p] >= SCNT_W'(STARVE_LIMIT));
    end
    pickPort  = (|urgent) ? rrPick(urgent, rrPtr) : rrPick(eligible, rrPtr);
    grantPort = lockVld ? lockPort : pickPort;
  end

  assign outValid     = lockVld || (|eligible);
  assign outPort      = grantPort;
  assign take         = outValid && outReady;
  assign strobe.take  = take;
  assign strobe.idle  = !outValid;
  assign strobe.port  = PORT_IDX_MAX'(grantPort);

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr    <= '0;
      lockVld  <= 1'b0;
      lockPort <= '0;
    end else if (take) begin
      rrPtr   <= (grantPort == PORT_W'(NUM_PORTS - 1)) ? '0 : grantPort + 1'b1;
      lockVld <= 1'b0;
    end else if (outValid) begin
      lockVld  <= 1'b1;
      lockPort <= grantPort;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rst) starveCnt[p] <= '0;
      else if (take) begin
        if (grantPort == PORT_W'(p)) starveCnt[p] <= '0;
        else if (headValid[p] && starveCnt[p] < SCNT_W'(STARVE_LIMIT))
          starveCnt[p] <= starveCnt[p] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_rr_arbiter.sv
module bank_rr_arbiter import rrarb_pkg::*; #(
  parameter int NUM_PORTS    = 4,
  parameter int NUM_BANKS    = 8,
  parameter int ADDR_W       = 16,
  parameter int FIFO_DEPTH   = 4,
  parameter int HIST_LEN     = 3,
  parameter int STARVE_LIMIT = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        inPush,
  input  logic [NUM_PORTS*BANK_W-1:0] inBank,
  input  logic [NUM_PORTS*ADDR_W-1:0] inAddr,
  output logic [NUM_PORTS-1:0]        inFull,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [PORT_W-1:0]           outPort,
  output logic [BANK_W-1:0]           outBank,
  output logic [ADDR_W-1:0]           outAddr
);
  arb_strobe_t                      strobe;
  logic [NUM_PORTS-1:0]             headValid;
  logic [NUM_PORTS-1:0][BANK_W-1:0] headBank;
  logic [NUM_BANKS-1:0]             bankBusy;

  rrarb_datapath #(
    .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
    .FIFO_DEPTH(FIFO_DEPTH), .HIST_LEN(HIST_LEN)
  ) u_dp (
    .clk(clk), .rst(rst), .inPush(inPush), .inBank(inBank), .inAddr(inAddr),
    .inFull(inFull), .strobe(strobe), .headValid(headValid), .headBank(headBank),
    .bankBusy(bankBusy), .outBank(outBank), .outAddr(outAddr)
  );

  rrarb_control #(
    .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .STARVE_LIMIT(STARVE_LIMIT)
  ) u_ctl (
    .clk(clk), .rst(rst), .headValid(headValid), .headBank(headBank),
    .bankBusy(bankBusy), .outReady(outReady), .outValid(outValid),
    .outPort(outPort), .strobe(strobe)
  );
endmodule

// File: rtl/rrarb_checker.sv
module rrarb_checker #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 16,
  parameter int HIST_LEN   = 3,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PORTS-1:0] inFull,
  input logic                 outValid,
  input logic                 outReady,
  input logic [PORT_W-1:0]    outPort,
  input logic [BANK_W-1:0]    outBank,
  input logic [ADDR_W-1:0]    outAddr
);
  // history rebuilt from the output handshake alone
  logic [BANK_W-1:0]   shBank [HIST_LEN];
  logic [HIST_LEN-1:0] shVld;
  logic [NUM_BANKS-1:0] shBusy;

  always_ff @(posedge clk) begin
    if (rst) shVld <= '0;
    else if (!outValid || outReady) shVld <= {shVld[HIST_LEN-2:0], outValid};
  end

  always_ff @(posedge clk) begin
    if (!outValid || outReady) begin
      shBank[0] <= outBank;
      for (int i = 1; i < HIST_LEN; i++) shBank[i] <= shBank[i-1];
    end
  end

  always_comb begin
    shBusy = '0;
    for (int i = 0; i < HIST_LEN; i++)
      if (shVld[i]) shBusy[shBank[i]] = 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !outValid); // R1

  AST_BANK_FREE: assert property (@(posedge clk) disable iff (rst) outValid |-> !shBusy[outBank]); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outPort) && $stable(outBank) && $stable(outAddr))); // R7

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_full
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (inFull[p] && !(outValid && outReady && outPort == PORT_W'(p))) |=> inFull[p]); // R3
  end
endmodule

bind bank_rr_arbiter rrarb_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .HIST_LEN(HIST_LEN)
) u_chk (
  .clk(clk), .rst(rst), .inFull(inFull), .outValid(outValid), .outReady(outReady),
  .outPort(outPort), .outBank(outBank), .outAddr(outAddr)
);

// File: tb/bank_rr_arbiter_test.sv
`timescale 1ns/1ps
module bank_rr_arbiter_test;
  localparam int NP = 4, NB = 8, AW = 16, DEPTH = 4, HL = 3, LIM = 2;
  localparam int BW = 3, PW = 2;

  typedef logic [BW+AW-1:0] item_t;

  logic clk = 1'b0, rst = 1'b1, outReady = 1'b0;
  logic [NP-1:0] inPush = '0;
  logic [NP*BW-1:0] inBank = '0;
  logic [NP*AW-1:0] inAddr = '0;
  logic [NP-1:0] inFull;
  logic outValid;
  logic [PW-1:0] outPort;
  logic [BW-1:0] outBank;
  logic [AW-1:0] outAddr;

  bank_rr_arbiter #(.NUM_PORTS(NP), .NUM_BANKS(NB), .ADDR_W(AW), .FIFO_DEPTH(DEPTH),
                    .HIST_LEN(HL), .STARVE_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .inPush(inPush), .inBank(inBank), .inAddr(inAddr),
    .inFull(inFull), .outValid(outValid), .outReady(outReady), .outPort(outPort),
    .outBank(outBank), .outAddr(outAddr));

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  int urgentWins = 0, idleWithData = 0, stallCycles = 0, bankSkips = 0;
  int pushedTotal = 0, poppedTotal = 0;
  bit finished = 0;
  int addrSeq = 1;

  // scoreboard / transaction model
  item_t mq [NP][$];
  int mHistBank [HL];
  bit mHistVld [HL];
  int mPtr, mLockPort;
  bit mLock;
  int mCnt [NP];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int p = 0; p < NP; p++) begin mq[p].delete(); mCnt[p] = 0; end
    for (int i = 0; i < HL; i++) begin mHistVld[i] = 0; mHistBank[i] = 0; end
    mPtr = 0; mLock = 0; mLockPort = 0;
  endtask

  function automatic bit inHist(input int bank);
    inHist = 0;
    for (int i = 0; i < HL; i++) if (mHistVld[i] && mHistBank[i] == bank) inHist = 1;
  endfunction

  task automatic histShift(input bit vld, input int bank);
    for (int i = HL-1; i > 0; i--) begin
      mHistVld[i] = mHistVld[i-1]; mHistBank[i] = mHistBank[i-1];
    end
    mHistVld[0] = vld; mHistBank[0] = bank;
  endtask

  task automatic modelStep();
    bit elig [NP];
    bit urg [NP];
    bit nonEmpty [NP];
    bit fullPre [NP];
    bit anyE, anyU, anyNE, expValid;
    int plain, pick, expP, firstNE;
    item_t head;
    anyE = 0; anyU = 0; anyNE = 0; plain = -1; pick = -1; firstNE = -1;
    for (int p = 0; p < NP; p++) begin
      nonEmpty[p] = mq[p].size() > 0;
      fullPre[p]  = mq[p].size() == DEPTH;
      elig[p] = nonEmpty[p] && !inHist(int'(mq[p][0][BW+AW-1:AW]));
      urg[p]  = elig[p] && mCnt[p] >= LIM;
      anyE |= elig[p]; anyU |= urg[p]; anyNE |= nonEmpty[p];
      // R3: full flag follows the FIFO fill level
      check(inFull[p] == fullPre[p], "R3", "inFull", longint'(inFull[p]), longint'(fullPre[p]));
    end
    for (int k = 0; k < NP; k++) begin
      int idx;
      idx = (mPtr + k) % NP;
      if (plain < 0 && elig[idx]) plain = idx;
      if (pick < 0 && urg[idx]) pick = idx;
      if (firstNE < 0 && nonEmpty[idx]) firstNE = idx;
    end
    if (pick < 0) pick = plain;
    expP = mLock ? mLockPort : pick;
    expValid = mLock || anyE;
    // R6: nothing offered when no head is eligible
    check(outValid == expValid, "R6", "outValid", longint'(outValid), longint'(expValid));
    if (!expValid && anyNE) idleWithData++;
    if (!mLock && anyU && plain != pick) urgentWins++;
    if (!mLock && anyE && firstNE >= 0 && !elig[firstNE]) bankSkips++;
    if (expValid) begin
      head = mq[expP][0];
      // R4 R5 R8 port choice; R7 while held by a stall
      check(int'(outPort) == expP, mLock ? "R7" : "R4", "outPort", longint'(outPort), longint'(expP));
      check(outBank == head[BW+AW-1:AW], "R2", "outBank", longint'(outBank), longint'(head[BW+AW-1:AW]));
      check(outAddr == head[AW-1:0], "R2", "outAddr", longint'(outAddr), longint'(head[AW-1:0]));
      if (outReady) begin
        // R9: acceptance pops and records the bank
        void'(mq[expP].pop_front());
        poppedTotal++;
        histShift(1, int'(head[BW+AW-1:AW]));
        for (int p = 0; p < NP; p++) begin
          if (p == expP) mCnt[p] = 0;
          else if (nonEmpty[p] && mCnt[p] < LIM) mCnt[p]++;
        end
        mPtr = (expP + 1) % NP;
        mLock = 0;
      end else begin
        stallCycles++;
        mLock = 1; mLockPort = expP;
      end
    end else begin
      histShift(0, 0);
    end
    for (int p = 0; p < NP; p++) begin
      if (inPush[p] && !fullPre[p]) begin
        mq[p].push_back({inBank[p*BW +: BW], inAddr[p*AW +: AW]});
        pushedTotal++;
      end
    end
  endtask

  always @(negedge clk) if (!rst && !finished) modelStep();

  task automatic stage(input int p, input int bank);
    inPush[p] = 1'b1;
    inBank[p*BW +: BW] = BW'(bank);
    inAddr[p*AW +: AW] = AW'(addrSeq);
    addrSeq++;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    inPush = '0;
  endtask

  task automatic doReset();
    rst = 1'b1; inPush = '0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    modelClear();
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle and not full right after reset
    check(outValid == 1'b0, "R1", "outValid after reset", longint'(outValid), 0);
    check(inFull == '0, "R1", "inFull after reset", longint'(inFull), 0);
    @(posedge clk); #1;
  endtask

  task automatic printSummary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      printSummary();
      $finish;
    end
  end

  initial begin
    doReset();

    // R5 same-bank spacing and R6 idle-slot aging
    outReady = 1'b1;
    stage(0, 5); stage(1, 5); stage(2, 6); tick();
    repeat (8) tick();
    stage(3, 1); tick(); stage(0, 1); tick();
    repeat (6) tick();

    // R7 stall holds the offer
    outReady = 1'b0;
    stage(0, 2); stage(1, 3); tick();
    stage(2, 4); tick();
    repeat (4) tick();
    outReady = 1'b1;
    repeat (6) tick();

    // R3 fill one port to full while stalled
    outReady = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin stage(3, i); tick(); end
    outReady = 1'b1;
    repeat (12) tick();

    // R8 urgency overrides plain round-robin order
    doReset();
    outReady = 1'b1;
    stage(1, 0); stage(2, 1); stage(3, 2); tick();
    stage(0, 0); stage(1, 3); tick();
    tick(); tick();
    stage(2, 4); tick();
    repeat (6) tick();

    // random traffic with random backpressure
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < NP; p++)
        if (!inFull[p] && $urandom_range(99) < 35) stage(p, $urandom_range(NB - 1));
      outReady = ($urandom_range(99) < 70);
      tick();
    end
    outReady = 1'b1;
    repeat (200) tick();

    // R2 nothing lost
    for (int p = 0; p < NP; p++)
      check(mq[p].size() == 0, "R2", "leftover entries", longint'(mq[p].size()), 0);
    check(pushedTotal == poppedTotal, "R2", "popped count", longint'(poppedTotal), longint'(pushedTotal));
    check(urgentWins > 0, "R8", "urgent overrides", longint'(urgentWins), 1);
    check(idleWithData > 0, "R6", "idle with blocked data", longint'(idleWithData), 1);
    check(stallCycles > 0, "R7", "stall cycles", longint'(stallCycles), 1);
    check(bankSkips > 0, "R5", "busy-bank skips", longint'(bankSkips), 1);

    finished = 1;
    printSummary();
    $finish;
  end
endmodule